// File: doc/BRIEF.md
# Peripheral Bus Cycle Decoder

This block sits in front of a parallel I/O peripheral. It watches the processor-side control lines and classifies each clock cycle as a read access, a write access, an interrupt acknowledge, a reset, or nothing. The result comes out as registered strobes, one clock after the inputs are sampled. It also latches which port and which register class (data or command) the current access targets, and it tells the data bus driver when the peripheral may drive.

Every control line is active-low except the daisy-chain enable input, which is active-high. Reset is not taken straight from its pin. The reset line is honoured only while the machine-cycle sync line is idle and no read with I/O request is under way. An interrupt acknowledge is decoded only when the daisy chain grants this device priority. In the default pulse mode, each read, write or acknowledge strobe marks only the first cycle of a run of identical cycles. A parameter selects per-cycle level strobes instead.

Top module: `bus_cycle_decoder`

## Requirements
- R1: With `rst_n`=1 and no acknowledge condition, `ce_n`=0, `iorq_n`=0 and `rd_n`=0 decode a read. `rd_stb` rises on the clock edge that samples them.
- R2: With `rst_n`=1 and no acknowledge condition, `ce_n`=0, `iorq_n`=0 and `rd_n`=1 decode a write. `wr_stb` rises on the clock edge that samples them.
- R3: With `rst_n`=1, the combination `iei`=1, `intack_n`=0, `sync_n`=0, `iorq_n`=0 and `chain_hold_n`=0 decodes an interrupt acknowledge and raises `iack_stb`. This ignores `ce_n` and `rd_n`, and it takes precedence over a read or a write decoded in the same cycle.
- R4: With `rst_n`=0 and `sync_n`=1, and `rd_n` and `iorq_n` not both 0, a reset is recognised. `rst_stb` is 1 after every such edge, and it clears `port_sel`, `cmd_sel` and `bus_oe` to 0.
- R5: With `rst_n`=0 and the R4 qualification not met, no cycle is decoded. All strobes and `bus_oe` are 0, and `port_sel` and `cmd_sel` keep their values.
- R6: On each cycle decoded as a read or a write, `addr[0]` is latched into `port_sel` (0 = first port, 1 = second port) and `addr[1]` into `cmd_sel` (1 = command register, 0 = data register). On any other non-reset cycle both hold.
- R7: `bus_oe` is 1 after an edge that decoded a read or an acknowledge, and 0 after any other edge.
- R8: In pulse mode, a read, write or acknowledge strobe is 1 only when the previous decoded cycle was of a different kind. A run of identical cycles yields one pulse.
- R9: At most one of `rd_stb`, `wr_stb`, `iack_stb` and `rst_stb` is 1 at any time.
- R10: When no condition of R1 to R4 holds, all strobes and `bus_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ce_n | input | 1 | Chip enable, active-low |
| iorq_n | input | 1 | I/O request, active-low |
| rd_n | input | 1 | Read, active-low |
| sync_n | input | 1 | Machine-cycle sync, active-low |
| rst_n | input | 1 | Reset line, active-low, qualified as in R4 |
| iei | input | 1 | Daisy-chain enable in, active-high |
| intack_n | input | 1 | Interrupt acknowledge request, active-low |
| chain_hold_n | input | 1 | Daisy-chain enable out level, low when this device holds priority |
| addr | input | PORT_BITS+1 | Low bits pick the port, top bit picks command or data |
| rd_stb | output | 1 | Read cycle strobe |
| wr_stb | output | 1 | Write cycle strobe |
| iack_stb | output | 1 | Interrupt acknowledge strobe |
| rst_stb | output | 1 | Reset recognised |
| port_sel | output | PORT_BITS | Latched port select |
| cmd_sel | output | 1 | Latched command-register select |
| bus_oe | output | 1 | Data bus drive enable; 0 means high impedance |

## Verification
Two kinds of cycle can fall in the same cycle. The first is an interrupt acknowledge coinciding with a read or a write. The bench raises every acknowledge line together with chip enable and read, then checks that only the acknowledge strobe fires and that the address latch does not move. The second is a reset request coinciding with a read under I/O request. The bench holds reset low with sync idle while read and I/O request are both low, and expects every output idle with the selects unchanged. A biased random run then mixes all lines, and a behavioural model judges every cycle.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
   typedef enum logic [2:0] {
      CYC_IDLE = 3'd0,
      CYC_RD   = 3'd1,
      CYC_WR   = 3'd2,
      CYC_IACK = 3'd3,
      CYC_RST  = 3'd4
   } cyc_e;
endpackage

// File: rtl/bcd_classify.sv
module bcd_classify
   import bcd_pkg::*;
(
   input  logic ce_n,
   input  logic iorq_n,
   input  logic rd_n,
   input  logic sync_n,
   input  logic rst_n,
   input  logic iei,
   input  logic intack_n,
   input  logic chain_hold_n,
   output cyc_e kind
);
   logic io_read_active;
   logic reset_ok;
   logic ack_hit;
   logic io_hit;

   always_comb begin
      io_read_active = !rd_n && !iorq_n;
      reset_ok       = sync_n && !io_read_active;
      ack_hit        = iei && !intack_n && !sync_n && !iorq_n && !chain_hold_n;
      io_hit         = !ce_n && !iorq_n;
      if (!rst_n)
         kind = reset_ok ? CYC_RST : CYC_IDLE;
      else if (ack_hit)
         kind = CYC_IACK;
      else if (io_hit)
         kind = rd_n ? CYC_WR : CYC_RD;
      else
         kind = CYC_IDLE;
   end
endmodule

// File: rtl/bcd_strobe.sv
module bcd_strobe
   import bcd_pkg::*;
#(
   parameter bit PULSE_MODE = 1'b1
) (
   input  logic clk,
   input  cyc_e kind,
   output logic rd_stb,
   output logic wr_stb,
   output logic iack_stb,
   output logic rst_stb
);
   always_ff @(posedge clk)
      rst_stb <= (kind == CYC_RST);

   generate
      if (PULSE_MODE) begin : g_pulse
         cyc_e prev_q;
         always_ff @(posedge clk) begin
            prev_q   <= kind;
            rd_stb   <= (kind == CYC_RD)   && (prev_q != CYC_RD);
            wr_stb   <= (kind == CYC_WR)   && (prev_q != CYC_WR);
            iack_stb <= (kind == CYC_IACK) && (prev_q != CYC_IACK);
         end
      end else begin : g_level
         always_ff @(posedge clk) begin
            rd_stb   <= (kind == CYC_RD);
            wr_stb   <= (kind == CYC_WR);
            iack_stb <= (kind == CYC_IACK);
         end
      end
   endgenerate
endmodule

// File: rtl/bcd_regsel.sv
module bcd_regsel
   import bcd_pkg::*;
#(
   parameter int PORT_BITS = 1,
   localparam int ADDR_W = PORT_BITS + 1
) (
   input  logic                 clk,
   input  cyc_e                 kind,
   input  logic [ADDR_W-1:0]    addr,
   output logic [PORT_BITS-1:0] port_sel,
   output logic                 cmd_sel,
   output logic                 bus_oe
);
   always_ff @(posedge clk) begin
      bus_oe <= (kind == CYC_RD) || (kind == CYC_IACK);
      if (kind == CYC_RST) begin
         port_sel <= '0;
         cmd_sel  <= 1'b0;
      end else if ((kind == CYC_RD) || (kind == CYC_WR)) begin
         port_sel <= addr[PORT_BITS-1:0];
         cmd_sel  <= addr[ADDR_W-1];
      end
   end
endmodule

// File: rtl/bus_cycle_decoder.sv
module bus_cycle_decoder
   import bcd_pkg::*;
#(
   parameter int PORT_BITS  = 1,
   parameter bit PULSE_MODE = 1'b1,
   localparam int ADDR_W = PORT_BITS + 1
) (
   input  logic                 clk,
   input  logic                 ce_n,
   input  logic                 iorq_n,
   input  logic                 rd_n,
   input  logic                 sync_n,
   input  logic                 rst_n,
   input  logic                 iei,
   input  logic                 intack_n,
   input  logic                 chain_hold_n,
   input  logic [ADDR_W-1:0]    addr,
   output logic                 rd_stb,
   output logic                 wr_stb,
   output logic                 iack_stb,
   output logic                 rst_stb,
   output logic [PORT_BITS-1:0] port_sel,
   output logic                 cmd_sel,
   output logic                 bus_oe
);
   generate
      if (PORT_BITS < 1 || PORT_BITS > 8) begin : g_bad_width
         $error("bus_cycle_decoder: PORT_BITS must lie in 1..8");
      end
   endgenerate

   cyc_e kind;

   bcd_classify u_classify (
      .ce_n         (ce_n),
      .iorq_n       (iorq_n),
      .rd_n         (rd_n),
      .sync_n       (sync_n),
      .rst_n        (rst_n),
      .iei          (iei),
      .intack_n     (intack_n),
      .chain_hold_n (chain_hold_n),
      .kind         (kind)
   );

   bcd_strobe #(.PULSE_MODE(PULSE_MODE)) u_strobe (
      .clk      (clk),
      .kind     (kind),
      .rd_stb   (rd_stb),
      .wr_stb   (wr_stb),
      .iack_stb (iack_stb),
      .rst_stb  (rst_stb)
   );

   bcd_regsel #(.PORT_BITS(PORT_BITS)) u_regsel (
      .clk      (clk),
      .kind     (kind),
      .addr     (addr),
      .port_sel (port_sel),
      .cmd_sel  (cmd_sel),
      .bus_oe   (bus_oe)
   );
endmodule

// File: rtl/bus_cycle_decoder_chk.sv
module bus_cycle_decoder_chk #(
   parameter int PORT_BITS  = 1,
   parameter bit PULSE_MODE = 1'b1,
   localparam int ADDR_W = PORT_BITS + 1
) (
   input logic                 clk,
   input logic                 ce_n,
   input logic                 iorq_n,
   input logic                 rd_n,
   input logic                 sync_n,
   input logic                 rst_n,
   input logic                 iei,
   input logic                 intack_n,
   input logic                 chain_hold_n,
   input logic [ADDR_W-1:0]    addr,
   input logic                 rd_stb,
   input logic                 wr_stb,
   input logic                 iack_stb,
   input logic                 rst_stb,
   input logic [PORT_BITS-1:0] port_sel,
   input logic                 cmd_sel,
   input logic                 bus_oe
);
   logic ack_in;
   assign ack_in = iei && !intack_n && !sync_n && !iorq_n && !chain_hold_n;

   a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_stb, wr_stb, iack_stb, rst_stb}));

   a_r1_read_source: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> $past(!ce_n && !iorq_n && !rd_n));

   a_r2_write_source: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(!ce_n && !iorq_n && rd_n));

   a_r3_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
      iack_stb |-> $past(ack_in));

   a_r3_ack_beats_io: assert property (@(posedge clk) disable iff (!rst_n)
      ack_in |=> (!rd_stb && !wr_stb));

   a_r7_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !bus_oe);

   a_r6_select_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ce_n || iorq_n)) |-> ($stable(port_sel) && $stable(cmd_sel)));

   generate
      if (PULSE_MODE) begin : g_pulse_chk
         a_r8_single_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            rd_stb |=> !rd_stb);
         a_r8_single_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            wr_stb |=> !wr_stb);
      end
   endgenerate
endmodule

bind bus_cycle_decoder bus_cycle_decoder_chk #(
   .PORT_BITS  (PORT_BITS),
   .PULSE_MODE (PULSE_MODE)
) u_chk (
   .clk          (clk),
   .ce_n         (ce_n),
   .iorq_n       (iorq_n),
   .rd_n         (rd_n),
   .sync_n       (sync_n),
   .rst_n        (rst_n),
   .iei          (iei),
   .intack_n     (intack_n),
   .chain_hold_n (chain_hold_n),
   .addr         (addr),
   .rd_stb       (rd_stb),
   .wr_stb       (wr_stb),
   .iack_stb     (iack_stb),
   .rst_stb      (rst_stb),
   .port_sel     (port_sel),
   .cmd_sel      (cmd_sel),
   .bus_oe       (bus_oe)
);

// File: tb/bus_cycle_decoder_tb.sv
module bus_cycle_decoder_tb;
   logic clk = 1'b0;
   logic ce_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, sync_n = 1'b1;
   logic rst_n = 1'b0, iei = 1'b0, intack_n = 1'b1, chain_hold_n = 1'b1;
   logic [1:0] addr = 2'b00;
   logic rd_stb, wr_stb, iack_stb, rst_stb, cmd_sel, bus_oe;
   logic [0:0] port_sel;

   int n_cmp = 0;
   int n_bad = 0;
   int prev_t = 0;
   logic e_rd, e_wr, e_ack, e_rst, e_oe, e_cmd;
   logic e_port;

   always #5 clk = ~clk;

   bus_cycle_decoder u_dut (
      .clk(clk), .ce_n(ce_n), .iorq_n(iorq_n), .rd_n(rd_n), .sync_n(sync_n),
      .rst_n(rst_n), .iei(iei), .intack_n(intack_n), .chain_hold_n(chain_hold_n),
      .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .iack_stb(iack_stb),
      .rst_stb(rst_stb), .port_sel(port_sel), .cmd_sel(cmd_sel), .bus_oe(bus_oe)
   );

   // 0 idle, 1 read, 2 write, 3 acknowledge, 4 reset
   function automatic int classify();
      if (!rst_n) return (sync_n && !(!rd_n && !iorq_n)) ? 4 : 0;
      if (iei && !intack_n && !sync_n && !iorq_n && !chain_hold_n) return 3;
      if (!ce_n && !iorq_n) return rd_n ? 2 : 1;
      return 0;
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   task automatic step(input string note);
      int t;
      @(posedge clk);
      t = classify();
      e_rst = (t == 4);
      e_rd  = (t == 1) && (prev_t != 1);
      e_wr  = (t == 2) && (prev_t != 2);
      e_ack = (t == 3) && (prev_t != 3);
      e_oe  = (t == 1) || (t == 3);
      if (t == 4) begin e_port = 1'b0; e_cmd = 1'b0; end
      else if (t == 1 || t == 2) begin e_port = addr[0]; e_cmd = addr[1]; end
      prev_t = t;
      @(negedge clk);
      chk({"R1 rd_stb ", note}, rd_stb, e_rd);
      chk({"R2 wr_stb ", note}, wr_stb, e_wr);
      chk({"R3 iack_stb ", note}, iack_stb, e_ack);
      chk({"R4 rst_stb ", note}, rst_stb, e_rst);
      chk({"R7 bus_oe ", note}, bus_oe, e_oe);
      chk({"R6 port_sel ", note}, port_sel[0], e_port);
      chk({"R6 cmd_sel ", note}, cmd_sel, e_cmd);
   endtask

   task automatic drive(input logic c, input logic q, input logic r, input logic s,
                        input logic rs, input logic ie, input logic ia, input logic ch,
                        input logic [1:0] a);
      ce_n = c; iorq_n = q; rd_n = r; sync_n = s; rst_n = rs;
      iei = ie; intack_n = ia; chain_hold_n = ch; addr = a;
   endtask

   initial begin : watchdog
      #1_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      e_port = 1'b0; e_cmd = 1'b0;
      // R4: reset recognised from time zero
      step("reset"); step("reset"); step("reset");
      // R10: idle
      drive(1,1,1,1,1,0,1,1,2'b11); step("R10 idle");
      // R1 read port 1 data, held: R8 one pulse
      drive(0,0,0,1,1,0,1,1,2'b01); step("R1 read"); step("R8 read held");
      // R2 write command port 0, then type change back to read
      drive(0,0,1,1,1,0,1,1,2'b10); step("R2 write"); step("R8 write held");
      drive(0,0,0,1,1,0,1,1,2'b11); step("R8 change to read");
      drive(1,1,1,1,1,0,1,1,2'b00); step("R6 hold on idle");
      // R3 acknowledge, then acknowledge overlapping a read
      drive(1,0,1,0,1,1,0,0,2'b00); step("R3 ack");
      drive(1,1,1,1,1,0,1,1,2'b00); step("idle");
      drive(0,0,0,0,1,1,0,0,2'b00); step("R3 ack over read");
      drive(0,0,1,0,1,0,0,0,2'b00); step("R3 iei low gives write");
      drive(0,0,1,0,1,1,0,1,2'b01); step("R3 chain held gives write");
      // R5: reset blocked by read with I/O request, and by active sync
      drive(0,0,0,1,0,0,1,1,2'b10); step("R5 blocked by read");
      drive(1,1,1,0,0,0,1,1,2'b10); step("R5 blocked by sync");
      drive(1,0,1,1,0,0,1,1,2'b10); step("R4 iorq only");
      drive(1,1,1,1,1,0,1,1,2'b00); step("idle");
      // R9 and the rest: biased random mix
      for (int i = 0; i < 600; i++) begin
         drive($urandom_range(0,2) == 0, $urandom_range(0,2) == 0, $urandom_range(0,1),
               $urandom_range(0,1), $urandom_range(0,9) != 0, $urandom_range(0,1),
               $urandom_range(0,1), $urandom_range(0,1), 2'($urandom_range(0,3)));
         step("random");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule